// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address into a physical address using a small table of segment descriptors. The upper bits of the logical address pick one descriptor. The lower bits form an offset. The offset is compared with the descriptor's length. If it fits, it is added to the descriptor's physical base. If it does not fit, the block reports a bounds fault and returns no address.

The table is loaded through a write port. Only a writer flagged as supervisor can change it. A write from user mode leaves the table untouched and produces a one-cycle privilege-error pulse. The table is combinational on the lookup side. Requests are answered one clock after they are presented, through a response register.

With the default parameters, the logical address is 16 bits: a 2-bit segment number and a 14-bit offset. The physical address is also 16 bits.

Top module: `seg_translator`

## Requirements
- R1: The segment number is `req_addr[15:14]` and the offset is `req_addr[13:0]`. When the offset is below the selected entry's length, `rsp_paddr` equals the entry base plus the offset, modulo 2^16, and `rsp_fault` is 0.
- R2: When the offset is greater than or equal to the selected entry's length, `rsp_fault` is 1.
- R3: Whenever `rsp_fault` is 1, `rsp_paddr` is 0.
- R4: After reset the table holds the following entries. Entry 0: base 0x4000, length 0x700. Entry 1: base 0x0000, length 0x500. Entry 2: length 0. Entry 3: base 0x2000, length 0x1000. An entry of length 0 faults on every offset.
- R5: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_paddr` and `rsp_fault` are 0.
- R6: A write with `wr_en` and `wr_sup` both high sets entry `wr_idx` to `wr_base` and `wr_len`. A request sampled on the same clock edge still sees the old entry. Requests sampled on later edges see the new one.
- R7: A write with `wr_en` high and `wr_sup` low changes no entry. It raises `priv_err` for exactly the next cycle. At all other times `priv_err` is low.
- R8: `rsp_write` repeats the `req_write` value of the request being answered. It is 0 when no response is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_sup | input | 1 | Writer is in supervisor mode |
| wr_idx | input | 2 | Entry to write |
| wr_base | input | 16 | New physical base |
| wr_len | input | 15 | New segment length |
| priv_err | output | 1 | Pulse: write refused because it came from user mode |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 16 | Logical address |
| req_write | input | 1 | Access type (1 = store, 0 = load) |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Bounds violation |
| rsp_write | output | 1 | Access type of the answered request |

## Verification
Every result of this block is due exactly one clock after the edge that samples its cause. This holds for the translated address, the fault flag, the echoed access type and the privilege-error pulse. It also holds for the point at which a supervisor write becomes visible to lookups.

The bench drives inputs on the falling edge and samples one time unit after the following rising edge. It compares against a bench-side copy of the table. The expected lookup result is computed from the table as it stood before that edge, and only then is the pending write applied to the copy. This makes a request and a write on the same edge resolve to the old entry, as R6 requires.

// File: rtl/seg_pkg.sv
// Package: shared reset contents for the segment table.
// Assumes: entries beyond the four described reset to base 0, length 0 (unmapped).
package seg_pkg;

    // Physical base loaded into entry idx at reset.
    function automatic logic [31:0] rst_base(input int idx);
        case (idx)
            0:       return 32'h0000_4000;
            1:       return 32'h0000_0000;
            3:       return 32'h0000_2000;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Segment length loaded into entry idx at reset; 0 means unmapped.
    function automatic logic [31:0] rst_len(input int idx);
        case (idx)
            0:       return 32'h0000_0700;
            1:       return 32'h0000_0500;
            3:       return 32'h0000_1000;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/seg_table.sv
// Module: seg_table
// Holds one base/length pair per segment and accepts supervisor-only writes.
// Assumes: writes take effect on the clock edge that samples them; the read
// port is combinational and shows the contents before that edge.
module seg_table #(
    parameter int SEG_W = 2,
    parameter int PA_W  = 16,
    parameter int LEN_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sup,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [LEN_W-1:0] rd_len,
    output logic             priv_err
);
    localparam int NSEG = 1 << SEG_W;

    logic [PA_W-1:0]  base_q [NSEG];
    logic [LEN_W-1:0] len_q  [NSEG];
    logic             priv_q;
    logic             user_wr;

    assign user_wr = wr_en && !wr_sup;

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        // Entry register: reset to its default, update on a supervisor write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= PA_W'(seg_pkg::rst_base(g));
                len_q[g]  <= LEN_W'(seg_pkg::rst_len(g));
            end else if (wr_en && wr_sup && (wr_idx == SEG_W'(g))) begin
                base_q[g] <= wr_base;
                len_q[g]  <= wr_len;
            end
        end

        // R7: a user-mode write leaves every entry unchanged.
        a_r7_user_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            user_wr |=> ($stable(base_q[g]) && $stable(len_q[g])));
    end

    // Privilege-error pulse, one cycle after a refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_q <= 1'b0;
        else        priv_q <= user_wr;
    end

    // Combinational read of the selected entry.
    always_comb begin
        rd_base = base_q[rd_idx];
        rd_len  = len_q[rd_idx];
    end

    assign priv_err = priv_q;

    a_r7_priv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        user_wr |=> priv_err);
    a_r7_priv_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !user_wr |=> !priv_err);
endmodule

// File: rtl/seg_xlate_path.sv
// Module: seg_xlate_path
// Combinational bound check and base-plus-offset adder for one lookup.
// Assumes: PA_W >= OFS_W and LEN_W == OFS_W + 1, so a length can cover the
// whole offset range; the sum wraps modulo 2^PA_W.
module seg_xlate_path #(
    parameter int OFS_W = 14,
    parameter int PA_W  = 16,
    parameter int LEN_W = 15
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [PA_W-1:0]  base,
    input  logic [LEN_W-1:0] seg_len,
    output logic [PA_W-1:0]  sum,
    output logic             oob
);
    // Bound compare and address add, evaluated in parallel.
    always_comb begin
        oob = (LEN_W'(offset) >= seg_len);
        sum = base + PA_W'(offset);
    end
endmodule

// File: rtl/seg_resp_reg.sv
// Module: seg_resp_reg
// Registers the lookup result; zeroes the address on a fault and everything when idle.
// Assumes: the inputs are settled combinational results of the current request.
module seg_resp_reg #(
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_write,
    input  logic [PA_W-1:0] in_sum,
    input  logic            in_oob,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic            rsp_write
);
    // Response register with address suppression on fault.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_write <= 1'b0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= in_oob;
            rsp_paddr <= in_oob ? '0 : in_sum;
            rsp_write <= in_write;
        end
    end

    a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && (rsp_paddr == '0) && !rsp_write));
endmodule

// File: rtl/seg_translator.sv
// Module: seg_translator (top)
// Translates segment-number/offset logical addresses through a base/length table.
// Assumes: one request per cycle at most; the answer appears one cycle later.
module seg_translator #(
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 2,
    parameter int PA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sup,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [PA_W-1:0]   wr_base,
    input  logic [ADDR_W-SEG_W:0] wr_len,
    output logic              priv_err,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_write
);
    localparam int OFS_W = ADDR_W - SEG_W;
    localparam int LEN_W = OFS_W + 1;

    logic [SEG_W-1:0] seg_sel;
    logic [OFS_W-1:0] offset;
    logic [PA_W-1:0]  ent_base;
    logic [LEN_W-1:0] ent_len;
    logic [PA_W-1:0]  sum;
    logic             oob;

    assign seg_sel = req_addr[ADDR_W-1:OFS_W];
    assign offset  = req_addr[OFS_W-1:0];

    seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LEN_W(LEN_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sup(wr_sup), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_len(wr_len),
        .rd_idx(seg_sel), .rd_base(ent_base), .rd_len(ent_len),
        .priv_err(priv_err)
    );

    seg_xlate_path #(.OFS_W(OFS_W), .PA_W(PA_W), .LEN_W(LEN_W)) u_path (
        .offset(offset), .base(ent_base), .seg_len(ent_len),
        .sum(sum), .oob(oob)
    );

    seg_resp_reg #(.PA_W(PA_W)) u_resp (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .in_write(req_write),
        .in_sum(sum), .in_oob(oob),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_write(rsp_write)
    );

    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r8_echo_type: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_write == $past(req_write)));
    a_r2_len_zero_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (ent_len == '0)) |=> rsp_fault);
endmodule

// File: tb/sim_seg_translator.sv
module sim_seg_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sup = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [15:0] wr_base = '0;
    logic [14:0] wr_len = '0;
    logic        priv_err;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_fault, rsp_write;
    logic [15:0] rsp_paddr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] m_base [4];
    logic [14:0] m_len  [4];

    always #10 clk = ~clk; // 50 MHz

    seg_translator u0 (.*);

    function automatic bit exp_fault(input logic [15:0] a);
        return {1'b0, a[13:0]} >= m_len[a[15:14]];
    endfunction

    function automatic logic [15:0] exp_paddr(input logic [15:0] a);
        return exp_fault(a) ? 16'h0 : 16'(m_base[a[15:14]] + {2'b00, a[13:0]});
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_base[0] = 16'h4000; m_len[0] = 15'h0700;
        m_base[1] = 16'h0000; m_len[1] = 15'h0500;
        m_base[2] = 16'h0000; m_len[2] = 15'h0000;
        m_base[3] = 16'h2000; m_len[3] = 15'h1000;
    endtask

    // One cycle: drive at negedge, check one unit after the next posedge.
    task automatic step(input bit v, input logic [15:0] a, input bit w,
                        input bit we, input bit sup, input logic [1:0] idx,
                        input logic [15:0] b, input logic [14:0] l, input string tag);
        bit f;
        logic [15:0] p;
        @(negedge clk);
        req_valid = v; req_addr = a; req_write = w;
        wr_en = we; wr_sup = sup; wr_idx = idx; wr_base = b; wr_len = l;
        f = v ? exp_fault(a) : 1'b0;
        p = v ? exp_paddr(a) : 16'h0;
        @(posedge clk); #1;
        chk({tag, " R5 valid"}, 32'(rsp_valid), 32'(v));
        chk({tag, " R2 fault"}, 32'(rsp_fault), 32'(f));
        chk({tag, " R1/R3 paddr"}, 32'(rsp_paddr), 32'(p));
        chk({tag, " R8 type"}, 32'(rsp_write), 32'(v & w));
        chk({tag, " R7 priv_err"}, 32'(priv_err), 32'(we & ~sup));
        if (we && sup) begin m_base[idx] = b; m_len[idx] = l; end
    endtask

    task automatic look(input logic [15:0] a, input string tag);
        step(1'b1, a, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 15'h0, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R5 reset valid", 32'(rsp_valid), 32'd0);
        chk("R7 reset priv", 32'(priv_err), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        // R4 / R1 / R2 directed boundaries on reset contents
        look(16'h06FF, "R4 seg0 last");
        look(16'h0700, "R4 seg0 first out");
        look(16'h4000, "R1 seg1 zero");
        look(16'h44FF, "R1 seg1 last");
        look(16'h4500, "R2 seg1 limit");
        look(16'h8000, "R4 seg2 unmapped");
        look(16'hBFFF, "R4 seg2 top");
        look(16'hCFFF, "R4 seg3 last");
        look(16'hD000, "R2 seg3 limit");
        step(1'b1, 16'hC123, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 15'h0, "R8 store");
        step(1'b0, 16'hC123, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 15'h0, "R5 idle");
        // R7: user write refused, entry 2 stays unmapped
        step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 2'd2, 16'h1000, 15'h0100, "R7 user write");
        look(16'h8010, "R7 after user write");
        // R6: supervisor write with same-edge request sees old entry
        step(1'b1, 16'h8010, 1'b0, 1'b1, 1'b1, 2'd2, 16'h1000, 15'h0100, "R6 same edge");
        look(16'h8010, "R6 new entry");
        look(16'h8100, "R6 new limit");
        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            bit we = ($urandom_range(0, 4) == 0);
            logic [14:0] l = ($urandom_range(0, 5) == 0) ? 15'h0 : 15'($urandom);
            step(1'($urandom_range(0, 3) != 0), 16'($urandom), 1'($urandom),
                 we, 1'($urandom), 2'($urandom), 16'($urandom), l, "rand");
        end
        step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 15'h0, "R5 drain");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule